// File: doc/BRIEF.md
# Extended-Precision Accumulator Compare Unit

This unit compares two operands for a DSP datapath. The datapath uses 24-bit data words and 56-bit accumulators. The first operand, S2, is always a full 56-bit accumulator. The second operand, S1, is either another 56-bit accumulator or a 24-bit data word.

A data word is widened before use. It fills bits 47..24, zeros fill bits 23..0, and its sign bit is copied into bits 55..48. The unit then forms S2 minus S1 at the full 56-bit width. The difference is used only to build a new condition-code byte, and it leaves the block through no port.

The condition-code byte is registered. It is loaded on a clock edge where the valid strobe is high and holds at every other edge. The two upper mode bits, limit and scaling, pass through from the current status byte. The remaining six flag bits come from the subtraction.

Top module: `acc_cmp_unit`

## Requirements
- R1: A synchronous active-high reset clears `ccr_o` to 0x00 at the next rising clock edge.
- R2: At a rising edge where `vld_i` is low, `ccr_o` keeps its value, whatever the other inputs are doing.
- R3: When `s1_is_word_i` is 1, S1 is built as follows. `s1_word_i` goes in bits 47..24 and zeros go in bits 23..0. Bits 55..48 are copies of `s1_word_i[23]`. When `s1_is_word_i` is 0, S1 is `s1_acc_i` and `s1_word_i` has no effect.
- R4: Bit 0 (carry) is set when S2 minus S1 borrows out of bit 55, that is, when S2 is below S1 as an unsigned 56-bit value.
- R5: Bit 1 (overflow) is set when S2 and S1 differ in bit 55 and the difference's bit 55 differs from S2's bit 55.
- R6: Bit 2 (zero) is set when all 56 bits of the difference are 0.
- R7: Bit 3 (negative) is a copy of bit 55 of the difference.
- R8: Bit 5 (extension-in-use) is set when bits 55..47 of the difference are not all equal.
- R9: Bit 4 (unnormalized) is set when bits 47 and 46 of the difference are equal.
- R10: The loaded value of bits 7..6 (limit, scaling) equals `ccr_i[7:6]`. Bits 5..0 of `ccr_i` have no effect.
- R11: S2 is used exactly as given. An extension byte that does not copy bit 47 is not corrected. For example, S2 = 0x00_800000_000000 compared with the word 0x000000 gives flags 0x20.
- R12: The flags from the inputs sampled at a valid edge appear on `ccr_o` right after that edge. Before that edge, `ccr_o` still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Load the compare result into the status byte |
| s1_is_word_i | input | 1 | 1: S1 is a 24-bit word; 0: S1 is a 56-bit accumulator |
| s2_acc_i | input | 56 | Accumulator operand S2 |
| s1_acc_i | input | 56 | Accumulator form of S1 |
| s1_word_i | input | 24 | Word form of S1 |
| ccr_i | input | 8 | Current status byte |
| ccr_o | output | 8 | Registered status byte |

## Verification
The carry and overflow flags can both be set by the same subtraction. So can the extension-in-use and unnormalized flags. Table entries that wrap the 56-bit range in both directions provoke these pairs, and each entry is judged against the full expected byte. A second collision is a reset and a valid strobe at the same edge, and the reset must win. The bench raises both together and expects 0x00.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int WORD_W = 24;
    localparam int EXT_W  = 8;
    localparam int ACC_W  = EXT_W + 2 * WORD_W;
    localparam int MSB    = ACC_W - 1;
    localparam int HI_B   = 2 * WORD_W - 1;

    typedef enum logic {
        OPND_ACC  = 1'b0,
        OPND_WORD = 1'b1
    } opnd_kind_e;

    typedef struct packed {
        logic scale;
        logic limit;
        logic ext;
        logic unnorm;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    typedef struct packed {
        logic             borrow;
        logic [ACC_W-1:0] diff;
    } sub_res_t;

    function automatic logic [ACC_W-1:0] widen_word(input logic [WORD_W-1:0] w);
        return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
    endfunction

    function automatic sub_res_t sub_full(input logic [ACC_W-1:0] a,
                                          input logic [ACC_W-1:0] b);
        sub_res_t r;
        logic [ACC_W:0] t;
        t = {1'b0, a} - {1'b0, b};
        r.borrow = t[ACC_W];
        r.diff   = t[ACC_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/cmp_align.sv
module cmp_align
    import cmp_pkg::*;
#(
    parameter int W_W = WORD_W,
    parameter int A_W = ACC_W
) (
    input  opnd_kind_e       kind_i,
    input  logic [A_W-1:0]   acc_i,
    input  logic [W_W-1:0]   word_i,
    output logic [A_W-1:0]   opnd_o
);
    logic [A_W-1:0] word_wide;

    always_comb begin
        word_wide = widen_word(word_i);
    end

    always_comb begin
        unique case (kind_i)
            OPND_WORD: opnd_o = word_wide;
            default:   opnd_o = acc_i;
        endcase
    end
endmodule

// File: rtl/cmp_flags.sv
module cmp_flags
    import cmp_pkg::*;
#(
    parameter int A_W = ACC_W,
    parameter int H_B = HI_B
) (
    input  logic [A_W-1:0] s2_i,
    input  logic [A_W-1:0] s1_i,
    output logic [5:0]     flags_o
);
    localparam int TOP  = A_W - 1;
    localparam int GRDN = TOP - H_B + 1;

    sub_res_t        res;
    logic            f_carry, f_ovf, f_zero, f_neg, f_unn, f_ext;
    logic [GRDN-1:0] guard;

    always_comb begin
        res     = sub_full(s2_i, s1_i);
        guard   = res.diff[TOP:H_B];
        f_carry = res.borrow;
        f_ovf   = (s2_i[TOP] ^ s1_i[TOP]) & (res.diff[TOP] ^ s2_i[TOP]);
        f_zero  = (res.diff == '0);
        f_neg   = res.diff[TOP];
        f_ext   = !((guard == '0) || (guard == '1));
        f_unn   = ~(res.diff[H_B] ^ res.diff[H_B-1]);
        flags_o = {f_ext, f_unn, f_neg, f_zero, f_ovf, f_carry};
    end
endmodule

// File: rtl/cmp_ccr_reg.sv
module cmp_ccr_reg
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [5:0] flags_i,
    input  logic [7:0] ccr_i,
    output ccr_t       ccr_q
);
    ccr_t nxt;
    logic unused_low;

    assign unused_low = ^ccr_i[5:0];

    always_comb begin
        nxt        = ccr_q;
        if (load_i) begin
            nxt.scale  = ccr_i[7];
            nxt.limit  = ccr_i[6];
            nxt.ext    = flags_i[5];
            nxt.unnorm = flags_i[4];
            nxt.neg    = flags_i[3];
            nxt.zero   = flags_i[2];
            nxt.ovf    = flags_i[1];
            nxt.carry  = flags_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ccr_q <= '0;
        else     ccr_q <= nxt;
    end
endmodule

// File: rtl/acc_cmp_unit.sv
module acc_cmp_unit
    import cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              s1_is_word_i,
    input  logic [ACC_W-1:0]  s2_acc_i,
    input  logic [ACC_W-1:0]  s1_acc_i,
    input  logic [WORD_W-1:0] s1_word_i,
    input  logic [7:0]        ccr_i,
    output logic [7:0]        ccr_o
);
    opnd_kind_e       kind;
    logic [ACC_W-1:0] s1_ext;
    logic [5:0]       flags;
    ccr_t             ccr_q;

    assign kind = s1_is_word_i ? OPND_WORD : OPND_ACC;

    cmp_align #(.W_W(WORD_W), .A_W(ACC_W)) u_align (
        .kind_i (kind),
        .acc_i  (s1_acc_i),
        .word_i (s1_word_i),
        .opnd_o (s1_ext)
    );

    cmp_flags #(.A_W(ACC_W), .H_B(HI_B)) u_flags (
        .s2_i    (s2_acc_i),
        .s1_i    (s1_ext),
        .flags_o (flags)
    );

    cmp_ccr_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .load_i  (vld_i),
        .flags_i (flags),
        .ccr_i   (ccr_i),
        .ccr_q   (ccr_q)
    );

    assign ccr_o = ccr_q;
endmodule

// File: rtl/acc_cmp_chk.sv
module acc_cmp_chk
    import cmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              vld_i,
    input logic              s1_is_word_i,
    input logic [ACC_W-1:0]  s2_acc_i,
    input logic [ACC_W-1:0]  s1_acc_i,
    input logic [7:0]        ccr_i,
    input logic [7:0]        ccr_o
);
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (ccr_o == 8'h00));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> (ccr_o == $past(ccr_o)));

    a_r10_mode_bits: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> (ccr_o[7:6] == $past(ccr_i[7:6])));

    a_r6_equal_zero: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !s1_is_word_i && s2_acc_i == s1_acc_i) |=> (ccr_o[2] && !ccr_o[0]));

    a_r5_same_sign_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !s1_is_word_i && s2_acc_i[ACC_W-1] == s1_acc_i[ACC_W-1]) |=> !ccr_o[1]);

    a_r7_zero_not_neg: assert property (@(posedge clk) disable iff (rst)
        ccr_o[2] |-> !ccr_o[3]);
endmodule

bind acc_cmp_unit acc_cmp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .vld_i        (vld_i),
    .s1_is_word_i (s1_is_word_i),
    .s2_acc_i     (s2_acc_i),
    .s1_acc_i     (s1_acc_i),
    .ccr_i        (ccr_i),
    .ccr_o        (ccr_o)
);

// File: tb/test_acc_cmp_unit.sv
`timescale 1ns/100ps
module test_acc_cmp_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        vld_i;
    logic        s1_is_word_i;
    logic [55:0] s2_acc_i;
    logic [55:0] s1_acc_i;
    logic [23:0] s1_word_i;
    logic [7:0]  ccr_i;
    logic [7:0]  ccr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    acc_cmp_unit i_acc_cmp_unit (
        .clk(clk), .rst(rst), .vld_i(vld_i), .s1_is_word_i(s1_is_word_i),
        .s2_acc_i(s2_acc_i), .s1_acc_i(s1_acc_i), .s1_word_i(s1_word_i),
        .ccr_i(ccr_i), .ccr_o(ccr_o)
    );

    // {word_sel, s2, s1_acc, s1_word, ccr_in, expected}
    localparam int NV = 8;
    localparam logic [152:0] VEC [NV] = '{
        {1'b1, 56'h00_000020_000000, 56'h0, 24'h000024, 8'h00, 8'h19}, // R3 R4 R7 R9
        {1'b0, 56'h00_000001_000000, 56'h00_000001_000000, 24'h0, 8'hC0, 8'hD4}, // R6 R10
        {1'b0, 56'h7F_FFFFFF_FFFFFF, 56'hFF_FFFFFF_FFFFFF, 24'h0, 8'h40, 8'h7B}, // R4 R5 R8 R9
        {1'b0, 56'h80_000000_000000, 56'h00_000000_000001, 24'h0, 8'h80, 8'hB2}, // R5 R8
        {1'b1, 56'h00_800000_000000, 56'h0, 24'h000000, 8'h3F, 8'h20}, // R11 R10
        {1'b1, 56'h00_000000_000000, 56'h0, 24'h800000, 8'h00, 8'h21}, // R3 sign ext
        {1'b0, 56'h00_400000_000000, 56'h0, 24'h0, 8'hFF, 8'hC0},      // R9 normalized
        {1'b0, 56'h00_000000_000002, 56'h00_000000_000001, 24'hFFFFFF, 8'h00, 8'h10} // R3 word ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: ccr_o=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [152:0] v);
        s1_is_word_i = v[152];
        s2_acc_i     = v[151:96];
        s1_acc_i     = v[95:40];
        s1_word_i    = v[39:16];
        ccr_i        = v[15:8];
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: ccr_o=%02h expected=done", ccr_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vld_i = 1'b0; drive(VEC[0]);
        repeat (3) @(negedge clk);
        check("R1 reset", ccr_o, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]); vld_i = 1'b1;
            @(negedge clk);
            vld_i = 1'b0;
            check($sformatf("R3-R11 vector %0d", i), ccr_o, VEC[i][7:0]);
        end

        // R2: hold while strobe low and inputs change
        drive(VEC[2]);
        repeat (3) @(negedge clk);
        check("R2 hold", ccr_o, 8'h10);

        // R12: not visible before the edge, visible after
        drive(VEC[6]); vld_i = 1'b1;
        #1;
        check("R12 before edge", ccr_o, 8'h10);
        @(negedge clk);
        vld_i = 1'b0;
        check("R12 after edge", ccr_o, 8'hC0);

        // R1: reset wins over a simultaneous strobe
        drive(VEC[2]); vld_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1 reset with strobe", ccr_o, 8'h00);
        rst = 1'b0; vld_i = 1'b0;
        @(negedge clk);
        check("R1 R2 after reset", ccr_o, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule